// File: doc/BRIEF.md
# SCSI Bus Phase and Interrupt Controller

This block is the host-facing register front end of a narrow parallel SCSI-style bus port. The host sees eight byte-wide offsets. Several of them mean one thing when read and another when written. The block drives the bus data and control lines from register bits. It watches the bus phase lines (MSG, CD, IO) and compares them with an expected phase that the host programs. The result of that comparison gates whether the data lines are driven, and it is also a source of interrupts.

Every bus input passes through a synchronizer before the block uses it. Falling handshake edges on the synchronized REQ or ACK lines capture input bytes while DMA mode is on. A single level interrupt request collects several events: selection, phase mismatch, parity error, loss of BSY and end of transfer. That request stays high until the host reads the clear offset. Writing any value to one of three offsets produces a one-cycle start strobe for an external DMA engine. A DMA request line paces that engine, either once per byte or for a whole block.

Top module: `scsi_phase_ctrl`

## Requirements
- R1: After synchronous reset, every writable register is zero. irq, drq, bus_data_oe, every start strobe and every bus control output read low.
- R2: Offsets 1, 2 and 3 read back the written control, mode and expected-phase registers. The control register keeps bits 7,4,3,2,1,0, so bits 6 and 5 read 0. The mode register keeps all 8 bits. The expected-phase register keeps bits 3..0 and reads 0 above them.
- R3: Offset 4 read gives the synchronized bus lines as RST b7, BSY b6, REQ b5, MSG b4, CD b3, IO b2, SEL b1, data parity b0. Offset 0 read gives the synchronized bus data.
- R4: bus_data_out always carries the byte last written to offset 0. bus_data_oe is high when mode bit 0 (arbitrate) is set. It is also high when control bit 0 (assert data) is set and the phase matches.
- R5: Offset 5 read (bus status) shows the following: phase match on b3, which is high when bus {MSG,CD,IO} equals expected-phase bits {2,1,0}; the IRQ mirror on b4; the DRQ mirror on b6; ATN on b1; ACK on b0.
- R6: Control bits drive the bus outputs as RST b7, BSY b3, SEL b2 and ATN b1. ACK comes from b4, and only in initiator mode. When mode bit 6 (target) is set, expected-phase bits drive REQ b3, MSG b2, CD b1 and IO b0. All four of those outputs are low in initiator mode.
- R7: Offset 4 write loads the select mask and leaves the offset 4 readback unchanged. irq rises when BSY is low, SEL is high and a data line whose mask bit is set is high.
- R8: A write of any value to offset 5, 6 or 7 pulses dma_send_start, dma_trecv_start or dma_irecv_start respectively. The pulse lasts one cycle and comes in the cycle after the write. The write changes no register.
- R9: With mode bit 1 (DMA) set, a falling edge captures the bus data into the input latch. That edge is on REQ in initiator mode and on ACK in target mode. Offset 6 reads the latch. The latch is not updated when DMA mode is off or when the other handshake line falls.
- R10: Mode bit 5 enables parity checking. With it set, a captured byte whose nine bits (data and parity) hold an even number of ones sets parity error (bus status b5). If mode bit 4 is also set, the error raises irq.
- R11: irq stays high after its cause goes away. A read of offset 7 (which returns 0) clears irq, the parity error flag, the busy error flag and the end-of-transfer flag.
- R12: With mode bit 2 (monitor busy) set, a fall of BSY sets busy error (bus status b2) and raises irq.
- R13: While DMA mode is on, the onset of a phase mismatch raises irq. If a transfer is active, it also ends that transfer: drq drops and end-of-transfer (bus status b7) sets.
- R14: A start strobe written while DMA mode is on begins a transfer. In per-byte mode, a send start raises drq and a receive start does not. During the transfer each captured handshake edge raises drq. An offset 6 read or an offset 0 write drops it. With mode bit 7 (block) set, drq stays high for the whole transfer. Clearing DMA mode ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 3 | Host register offset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for hst_addr |
| irq | output | 1 | Interrupt request level |
| drq | output | 1 | DMA request |
| dma_send_start | output | 1 | DMA send start strobe |
| dma_trecv_start | output | 1 | Target-mode DMA receive start strobe |
| dma_irecv_start | output | 1 | Initiator-mode DMA receive start strobe |
| bus_data_in | input | 8 | Bus data lines, active high |
| bus_dbp_in | input | 1 | Bus data parity line |
| bus_rst_in | input | 1 | Bus RST line |
| bus_bsy_in | input | 1 | Bus BSY line |
| bus_req_in | input | 1 | Bus REQ line |
| bus_ack_in | input | 1 | Bus ACK line |
| bus_atn_in | input | 1 | Bus ATN line |
| bus_sel_in | input | 1 | Bus SEL line |
| bus_msg_in | input | 1 | Bus MSG phase line |
| bus_cd_in | input | 1 | Bus CD phase line |
| bus_io_in | input | 1 | Bus IO phase line |
| bus_data_out | output | 8 | Data driven onto the bus |
| bus_data_oe | output | 1 | Data drive enable |
| bus_rst_out | output | 1 | Drive RST |
| bus_bsy_out | output | 1 | Drive BSY |
| bus_sel_out | output | 1 | Drive SEL |
| bus_atn_out | output | 1 | Drive ATN |
| bus_ack_out | output | 1 | Drive ACK (initiator) |
| bus_req_out | output | 1 | Drive REQ (target) |
| bus_msg_out | output | 1 | Drive MSG (target) |
| bus_cd_out | output | 1 | Drive CD (target) |
| bus_io_out | output | 1 | Drive IO (target) |

## Verification
The assertions assume that each bus input level holds for longer than the synchronizer depth. They also assume that the host never raises read and write in the same cycle. Under those conditions an edge detected on the synchronized lines is a real bus event that happens exactly once. The bench drives every bus and host input on the falling clock edge. It holds each bus level for five cycles before it samples or makes the next change. Random phases, data and control bits are applied with a fixed seed, and directed sequences cover the handshake, parity, busy and mismatch cases.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_PHASE = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_BUSST = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 3'd7;

    // synchronized view of every bus input
    typedef struct packed {
        logic              rst;
        logic              bsy;
        logic              req;
        logic              msg;
        logic              cd;
        logic              io;
        logic              sel;
        logic              dbp;
        logic              atn;
        logic              ack;
        logic [BYTE_W-1:0] data;
    } bus_in_t;

    localparam int BUS_IN_W = $bits(bus_in_t);

    // mode register, field order is the bit order
    typedef struct packed {
        logic blk;
        logic tgt;
        logic par_chk;
        logic par_irq;
        logic eop_irq;
        logic mon_bsy;
        logic dma;
        logic arb;
    } mode_t;

    typedef struct packed {
        logic rst;
        logic ack;
        logic bsy;
        logic sel;
        logic atn;
        logic data;
    } ctrl_t;

    typedef struct packed {
        logic req;
        logic msg;
        logic cd;
        logic io;
    } phase_t;

    // bus status byte, field order is the bit order
    typedef struct packed {
        logic end_dma;
        logic drq;
        logic par_err;
        logic irq;
        logic phase_ok;
        logic bsy_err;
        logic atn;
        logic ack;
    } busst_t;

    function automatic logic odd_par_ok(logic [BYTE_W-1:0] d, logic p);
        return ^{d, p};
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(bus_in_t b);
        return {b.rst, b.bsy, b.req, b.msg, b.cd, b.io, b.sel, b.dbp};
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spc_regs.sv
module spc_regs
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cur_data,
    input  logic [BYTE_W-1:0] status,
    input  busst_t            busst,
    input  logic [BYTE_W-1:0] in_latch,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] odr,
    output ctrl_t             ctrl,
    output mode_t             mode,
    output phase_t            phase,
    output logic [BYTE_W-1:0] sel_mask,
    output logic              start_send,
    output logic              start_trecv,
    output logic              start_irecv,
    output logic              wr_send_hit,
    output logic              wr_recv_hit,
    output logic              wr_odr_hit,
    output logic              rd_latch_hit,
    output logic              rd_clear_hit
);
    logic [7:0] wr_hit;

    always_comb begin
        wr_hit = '0;
        if (wr) wr_hit[addr] = 1'b1;
    end

    assign wr_send_hit  = wr_hit[OFS_BUSST];
    assign wr_recv_hit  = wr_hit[OFS_LATCH] | wr_hit[OFS_CLEAR];
    assign wr_odr_hit   = wr_hit[OFS_DATA];
    assign rd_latch_hit = rd && (addr == OFS_LATCH);
    assign rd_clear_hit = rd && (addr == OFS_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            odr         <= '0;
            ctrl        <= '0;
            mode        <= '0;
            phase       <= '0;
            sel_mask    <= '0;
            start_send  <= 1'b0;
            start_trecv <= 1'b0;
            start_irecv <= 1'b0;
        end else begin
            start_send  <= wr_hit[OFS_BUSST];
            start_trecv <= wr_hit[OFS_LATCH];
            start_irecv <= wr_hit[OFS_CLEAR];
            if (wr_hit[OFS_DATA])  odr <= wdata;
            if (wr_hit[OFS_CTRL]) begin
                ctrl.rst  <= wdata[7];
                ctrl.ack  <= wdata[4];
                ctrl.bsy  <= wdata[3];
                ctrl.sel  <= wdata[2];
                ctrl.atn  <= wdata[1];
                ctrl.data <= wdata[0];
            end
            if (wr_hit[OFS_MODE])  mode  <= mode_t'(wdata);
            if (wr_hit[OFS_PHASE]) phase <= phase_t'(wdata[3:0]);
            if (wr_hit[OFS_STAT])  sel_mask <= wdata;
        end
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rdata = cur_data;
            OFS_CTRL:  rdata = {ctrl.rst, 2'b00, ctrl.ack, ctrl.bsy,
                                ctrl.sel, ctrl.atn, ctrl.data};
            OFS_MODE:  rdata = mode;
            OFS_PHASE: rdata = {4'b0000, phase};
            OFS_STAT:  rdata = status;
            OFS_BUSST: rdata = busst;
            OFS_LATCH: rdata = in_latch;
            default:   rdata = '0;
        endcase
    end

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_send, start_trecv, start_irecv}));

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (start_send && !wr_send_hit) |=> !start_send);
endmodule

// File: rtl/spc_events.sv
module spc_events
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_in_t           bus,
    input  mode_t             mode,
    input  logic              assert_data,
    input  logic [2:0]        exp_phase,
    input  logic [BYTE_W-1:0] sel_mask,
    input  logic              wr_send_hit,
    input  logic              wr_recv_hit,
    input  logic              wr_odr_hit,
    input  logic              rd_latch_hit,
    input  logic              rd_clear_hit,
    output logic              irq,
    output logic              drq,
    output logic              data_oe,
    output logic [BYTE_W-1:0] in_latch,
    output logic [BYTE_W-1:0] status,
    output busst_t            busst
);
    logic bsy_q, req_q, ack_q, sel_cond_q, mm_q;
    logic par_err, bsy_err, end_dma, dma_active, drq_byte;

    logic pm, hs_fall, take, par_ev, bsy_ev, sel_cond, sel_ev;
    logic mm_cond, mm_ev, eop_ev, irq_set, start;

    assign pm       = ({bus.msg, bus.cd, bus.io} == exp_phase);
    assign data_oe  = mode.arb | (assert_data & pm);
    assign hs_fall  = mode.tgt ? (ack_q & ~bus.ack) : (req_q & ~bus.req);
    assign take     = mode.dma & hs_fall;
    assign par_ev   = take & mode.par_chk & ~odd_par_ok(bus.data, bus.dbp);
    assign bsy_ev   = mode.mon_bsy & bsy_q & ~bus.bsy;
    assign sel_cond = ~bus.bsy & bus.sel & (|(bus.data & sel_mask));
    assign sel_ev   = sel_cond & ~sel_cond_q;
    assign mm_cond  = mode.dma & ~pm;
    assign mm_ev    = mm_cond & ~mm_q;
    assign eop_ev   = mm_ev & dma_active;
    assign start    = wr_send_hit | wr_recv_hit;
    assign irq_set  = sel_ev | mm_ev | bsy_ev | (par_ev & mode.par_irq)
                    | (eop_ev & mode.eop_irq);

    always_ff @(posedge clk) begin
        if (rst) begin
            bsy_q      <= 1'b0;
            req_q      <= 1'b0;
            ack_q      <= 1'b0;
            sel_cond_q <= 1'b0;
            mm_q       <= 1'b0;
        end else begin
            bsy_q      <= bus.bsy;
            req_q      <= bus.req;
            ack_q      <= bus.ack;
            sel_cond_q <= sel_cond;
            mm_q       <= mm_cond;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            par_err  <= 1'b0;
            bsy_err  <= 1'b0;
            end_dma  <= 1'b0;
            in_latch <= '0;
        end else begin
            if (irq_set)           irq <= 1'b1;
            else if (rd_clear_hit) irq <= 1'b0;
            if (par_ev)            par_err <= 1'b1;
            else if (rd_clear_hit) par_err <= 1'b0;
            if (bsy_ev)            bsy_err <= 1'b1;
            else if (rd_clear_hit) bsy_err <= 1'b0;
            if (eop_ev)                     end_dma <= 1'b1;
            else if (rd_clear_hit || start) end_dma <= 1'b0;
            if (take) in_latch <= bus.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_active <= 1'b0;
            drq_byte   <= 1'b0;
        end else begin
            if (!mode.dma)  dma_active <= 1'b0;
            else if (mm_ev) dma_active <= 1'b0;
            else if (start) dma_active <= 1'b1;

            if (wr_send_hit)                    drq_byte <= 1'b1;
            else if (wr_recv_hit)               drq_byte <= 1'b0;
            else if (hs_fall && dma_active)     drq_byte <= 1'b1;
            else if (rd_latch_hit || wr_odr_hit) drq_byte <= 1'b0;
        end
    end

    assign drq    = dma_active & (mode.blk | drq_byte);
    assign status = status_byte(bus);
    assign busst  = '{end_dma: end_dma, drq: drq, par_err: par_err, irq: irq,
                      phase_ok: pm, bsy_err: bsy_err, atn: bus.atn, ack: bus.ack};

    a_r13_mismatch_drops_drq: assert property (@(posedge clk) disable iff (rst)
        mm_ev |=> !drq);

    a_r11_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (rd_clear_hit && !irq_set) |=> !irq);

    a_r10_parity_flag: assert property (@(posedge clk) disable iff (rst)
        par_ev |=> busst.par_err);

    a_r12_busy_flag: assert property (@(posedge clk) disable iff (rst)
        bsy_ev |=> (busst.bsy_err && irq));

    a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_set));
endmodule

// File: rtl/scsi_phase_ctrl.sv
module scsi_phase_ctrl
    import spc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [BYTE_W-1:0] hst_wdata,
    output logic [BYTE_W-1:0] hst_rdata,
    output logic              irq,
    output logic              drq,
    output logic              dma_send_start,
    output logic              dma_trecv_start,
    output logic              dma_irecv_start,
    input  logic [BYTE_W-1:0] bus_data_in,
    input  logic              bus_dbp_in,
    input  logic              bus_rst_in,
    input  logic              bus_bsy_in,
    input  logic              bus_req_in,
    input  logic              bus_ack_in,
    input  logic              bus_atn_in,
    input  logic              bus_sel_in,
    input  logic              bus_msg_in,
    input  logic              bus_cd_in,
    input  logic              bus_io_in,
    output logic [BYTE_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              bus_rst_out,
    output logic              bus_bsy_out,
    output logic              bus_sel_out,
    output logic              bus_atn_out,
    output logic              bus_ack_out,
    output logic              bus_req_out,
    output logic              bus_msg_out,
    output logic              bus_cd_out,
    output logic              bus_io_out
);
    bus_in_t           raw, bus_s;
    busst_t            busst;
    ctrl_t             ctrl;
    mode_t             mode;
    phase_t            phase;
    logic [BYTE_W-1:0] odr, sel_mask, in_latch, status;
    logic wr_send_hit, wr_recv_hit, wr_odr_hit, rd_latch_hit, rd_clear_hit;

    assign raw = '{rst: bus_rst_in, bsy: bus_bsy_in, req: bus_req_in,
                   msg: bus_msg_in, cd: bus_cd_in, io: bus_io_in,
                   sel: bus_sel_in, dbp: bus_dbp_in, atn: bus_atn_in,
                   ack: bus_ack_in, data: bus_data_in};

    spc_sync #(.W(BUS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(bus_s)
    );

    spc_regs u_regs (
        .clk(clk), .rst(rst), .addr(hst_addr), .wr(hst_wr), .rd(hst_rd),
        .wdata(hst_wdata), .cur_data(bus_s.data), .status(status),
        .busst(busst), .in_latch(in_latch), .rdata(hst_rdata), .odr(odr),
        .ctrl(ctrl), .mode(mode), .phase(phase), .sel_mask(sel_mask),
        .start_send(dma_send_start), .start_trecv(dma_trecv_start),
        .start_irecv(dma_irecv_start), .wr_send_hit(wr_send_hit),
        .wr_recv_hit(wr_recv_hit), .wr_odr_hit(wr_odr_hit),
        .rd_latch_hit(rd_latch_hit), .rd_clear_hit(rd_clear_hit)
    );

    spc_events u_events (
        .clk(clk), .rst(rst), .bus(bus_s), .mode(mode),
        .assert_data(ctrl.data), .exp_phase({phase.msg, phase.cd, phase.io}),
        .sel_mask(sel_mask), .wr_send_hit(wr_send_hit),
        .wr_recv_hit(wr_recv_hit), .wr_odr_hit(wr_odr_hit),
        .rd_latch_hit(rd_latch_hit), .rd_clear_hit(rd_clear_hit),
        .irq(irq), .drq(drq), .data_oe(bus_data_oe), .in_latch(in_latch),
        .status(status), .busst(busst)
    );

    assign bus_data_out = odr;
    assign bus_rst_out  = ctrl.rst;
    assign bus_bsy_out  = ctrl.bsy;
    assign bus_sel_out  = ctrl.sel;
    assign bus_atn_out  = ctrl.atn;
    assign bus_ack_out  = ctrl.ack & ~mode.tgt;
    assign bus_req_out  = phase.req & mode.tgt;
    assign bus_msg_out  = phase.msg & mode.tgt;
    assign bus_cd_out   = phase.cd  & mode.tgt;
    assign bus_io_out   = phase.io  & mode.tgt;

    a_r6_target_lines_quiet: assert property (@(posedge clk) disable iff (rst)
        !mode.tgt |-> !(bus_req_out || bus_msg_out || bus_cd_out || bus_io_out));
endmodule

// File: tb/test_scsi_phase_ctrl.sv
module test_scsi_phase_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] addr = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic irq, drq, s_send, s_trecv, s_irecv;
    logic [7:0] b_data = '0;
    logic b_dbp = 0, b_rst = 0, b_bsy = 0, b_req = 0, b_ack = 0, b_atn = 0;
    logic b_sel = 0, b_msg = 0, b_cd = 0, b_io = 0;
    logic [7:0] o_data;
    logic o_oe, o_rst, o_bsy, o_sel, o_atn, o_ack, o_req, o_msg, o_cd, o_io;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scsi_phase_ctrl i_scsi_phase_ctrl (
        .clk(clk), .rst(rst), .hst_addr(addr), .hst_wr(wr), .hst_rd(rd),
        .hst_wdata(wdata), .hst_rdata(rdata), .irq(irq), .drq(drq),
        .dma_send_start(s_send), .dma_trecv_start(s_trecv),
        .dma_irecv_start(s_irecv), .bus_data_in(b_data), .bus_dbp_in(b_dbp),
        .bus_rst_in(b_rst), .bus_bsy_in(b_bsy), .bus_req_in(b_req),
        .bus_ack_in(b_ack), .bus_atn_in(b_atn), .bus_sel_in(b_sel),
        .bus_msg_in(b_msg), .bus_cd_in(b_cd), .bus_io_in(b_io),
        .bus_data_out(o_data), .bus_data_oe(o_oe), .bus_rst_out(o_rst),
        .bus_bsy_out(o_bsy), .bus_sel_out(o_sel), .bus_atn_out(o_atn),
        .bus_ack_out(o_ack), .bus_req_out(o_req), .bus_msg_out(o_msg),
        .bus_cd_out(o_cd), .bus_io_out(o_io)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        #1;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0;
        #1;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
        #1;
    endtask

    task automatic pulse_req();
        b_req = 1'b1; settle(); b_req = 1'b0; settle();
    endtask

    function automatic logic [7:0] exp_status();
        return {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp};
    endfunction

    function automatic logic exp_oe(logic arb, logic ad, logic [2:0] tp);
        return arb | (ad & ({b_msg, b_cd, b_io} == tp));
    endfunction

    initial begin
        logic [7:0] v;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 drq", {7'b0, drq}, 8'h00);
        chk("R1 oe/strobes", {4'b0, o_oe, s_send, s_trecv, s_irecv}, 8'h00);
        chk("R1 ctrl outs", {o_rst, o_bsy, o_sel, o_atn, o_ack, o_req, o_msg, o_cd}, 8'h00);
        hrd(3'd1, v); chk("R1 ctrl reg", v, 8'h00);
        hrd(3'd2, v); chk("R1 mode reg", v, 8'h00);
        hrd(3'd3, v); chk("R1 phase reg", v, 8'h00);

        // R2 readback
        hwr(3'd1, 8'hFF); hrd(3'd1, v); chk("R2 ctrl readback", v, 8'h9F);
        hwr(3'd1, 8'h00);
        hwr(3'd2, 8'h5A); hrd(3'd2, v); chk("R2 mode readback", v, 8'h5A);
        hwr(3'd2, 8'h00);
        hwr(3'd3, 8'hFF); hrd(3'd3, v); chk("R2 phase readback", v, 8'h0F);
        hwr(3'd3, 8'h00);

        // R6 control outputs
        hwr(3'd1, 8'h9E);
        chk("R6 initiator outs", {o_rst, o_ack, o_bsy, o_sel, o_atn, 3'b0}, 8'hF8);
        hwr(3'd3, 8'h0F);
        chk("R6 target lines off in initiator", {4'b0, o_req, o_msg, o_cd, o_io}, 8'h00);
        hwr(3'd2, 8'h40);
        chk("R6 target outs", {3'b0, o_ack, o_req, o_msg, o_cd, o_io}, 8'h0F);
        hwr(3'd2, 8'h00); hwr(3'd1, 8'h00); hwr(3'd3, 8'h00);

        // R3 R4 R5 random patterns
        for (int i = 0; i < 40; i++) begin
            logic [2:0] tp;
            logic ad, arb;
            logic [7:0] od;
            r = $urandom;
            {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp} = r[7:0];
            b_data = r[15:8];
            b_atn = r[16]; b_ack = r[17];
            tp = r[20:18]; ad = r[21]; arb = r[22] & r[23];
            od = 8'($urandom);
            hwr(3'd3, {5'b0, tp}); hwr(3'd1, {7'b0, ad});
            hwr(3'd2, {7'b0, arb}); hwr(3'd0, od);
            settle();
            hrd(3'd4, v); chk("R3 status", v, exp_status());
            hrd(3'd0, v); chk("R3 bus data", v, b_data);
            hrd(3'd5, v);
            chk("R5 phase match atn ack", {5'b0, v[3], v[1], v[0]},
                {5'b0, ({b_msg, b_cd, b_io} == tp), b_atn, b_ack});
            chk("R4 oe", {7'b0, o_oe}, {7'b0, exp_oe(arb, ad, tp)});
            chk("R4 data out", o_data, od);
        end
        {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp} = 8'h00;
        b_data = 8'h00; b_atn = 0; b_ack = 0;
        hwr(3'd3, 8'h00); hwr(3'd1, 8'h00); hwr(3'd2, 8'h00);
        settle();
        hrd(3'd7, v); chk("R11 clear read value", v, 8'h00);
        chk("R11 irq clear after random", {7'b0, irq}, 8'h00);

        // R7 selection
        hwr(3'd4, 8'h04);
        hrd(3'd4, v); chk("R7 mask write leaves status", v, 8'h00);
        b_data = 8'h08; b_sel = 1'b1; settle();
        chk("R7 unmasked line no irq", {7'b0, irq}, 8'h00);
        b_sel = 1'b0; settle();
        b_data = 8'h04; b_sel = 1'b1; settle();
        chk("R7 select irq", {7'b0, irq}, 8'h01);
        hrd(3'd5, v); chk("R5 irq mirror", {7'b0, v[4]}, 8'h01);
        b_sel = 1'b0; b_data = 8'h00; settle();
        chk("R11 irq held", {7'b0, irq}, 8'h01);
        hrd(3'd7, v);
        chk("R11 irq cleared", {7'b0, irq}, 8'h00);
        hwr(3'd4, 8'h00);

        // R8 start strobes
        hwr(3'd5, 8'h00);
        chk("R8 send strobe", {5'b0, s_send, s_trecv, s_irecv}, 8'h04);
        @(negedge clk); #1;
        chk("R8 send strobe ends", {5'b0, s_send, s_trecv, s_irecv}, 8'h00);
        hwr(3'd6, 8'hA5);
        chk("R8 target recv strobe", {5'b0, s_send, s_trecv, s_irecv}, 8'h02);
        hwr(3'd7, 8'h3C);
        chk("R8 initiator recv strobe", {5'b0, s_send, s_trecv, s_irecv}, 8'h01);
        hrd(3'd2, v); chk("R8 mode untouched", v, 8'h00);
        hrd(3'd3, v); chk("R8 phase untouched", v, 8'h00);
        chk("R14 no transfer without DMA mode", {7'b0, drq}, 8'h00);

        // R9 R14 receive
        hwr(3'd2, 8'h02);
        hwr(3'd7, 8'h00); settle();
        chk("R14 recv start no drq", {7'b0, drq}, 8'h00);
        b_data = 8'h3C; pulse_req();
        chk("R14 drq after byte", {7'b0, drq}, 8'h01);
        hrd(3'd6, v); chk("R9 latch on REQ fall", v, 8'h3C);
        chk("R14 drq drops on read", {7'b0, drq}, 8'h00);
        hwr(3'd2, 8'h42);
        b_data = 8'h11; pulse_req();
        hrd(3'd6, v); chk("R9 REQ ignored in target", v, 8'h3C);
        b_data = 8'h55; b_ack = 1'b1; settle(); b_ack = 1'b0; settle();
        hrd(3'd6, v); chk("R9 latch on ACK fall", v, 8'h55);
        hwr(3'd2, 8'h00);
        b_data = 8'h77; pulse_req();
        hrd(3'd6, v); chk("R9 no latch DMA off", v, 8'h55);

        // R10 parity
        hwr(3'd2, 8'h32);
        b_data = 8'h01; b_dbp = 1'b0; pulse_req();
        hrd(3'd5, v); chk("R10 good parity", {7'b0, v[5]}, 8'h00);
        chk("R10 no irq good parity", {7'b0, irq}, 8'h00);
        b_dbp = 1'b1; pulse_req();
        hrd(3'd5, v); chk("R10 parity error", {7'b0, v[5]}, 8'h01);
        chk("R10 parity irq", {7'b0, irq}, 8'h01);
        hrd(3'd7, v);
        hrd(3'd5, v); chk("R11 parity cleared", {7'b0, v[5]}, 8'h00);
        chk("R11 irq cleared parity", {7'b0, irq}, 8'h00);
        b_dbp = 1'b0; b_data = 8'h00;
        hwr(3'd2, 8'h00);

        // R12 busy loss
        hwr(3'd2, 8'h04);
        b_bsy = 1'b1; settle(); b_bsy = 1'b0; settle();
        hrd(3'd5, v); chk("R12 busy error", {7'b0, v[2]}, 8'h01);
        chk("R12 busy irq", {7'b0, irq}, 8'h01);
        hrd(3'd7, v);
        hrd(3'd5, v); chk("R11 busy cleared", {7'b0, v[2]}, 8'h00);
        hwr(3'd2, 8'h00);

        // R13 R14 send and mismatch
        hwr(3'd2, 8'h02);
        hwr(3'd5, 8'h00); settle();
        chk("R14 send start drq", {7'b0, drq}, 8'h01);
        hwr(3'd0, 8'h99);
        chk("R14 drq drops on data write", {7'b0, drq}, 8'h00);
        pulse_req();
        chk("R14 drq on handshake", {7'b0, drq}, 8'h01);
        chk("R13 no irq while matched", {7'b0, irq}, 8'h00);
        b_io = 1'b1; settle();
        chk("R13 mismatch irq", {7'b0, irq}, 8'h01);
        chk("R13 mismatch drops drq", {7'b0, drq}, 8'h00);
        hrd(3'd5, v); chk("R13 end of transfer", {7'b0, v[7]}, 8'h01);
        hrd(3'd7, v);
        hrd(3'd5, v); chk("R11 end flag cleared", {7'b0, v[7]}, 8'h00);
        b_io = 1'b0; settle();

        // R14 block mode
        hwr(3'd2, 8'h82);
        hwr(3'd6, 8'h00); settle();
        chk("R14 block drq", {7'b0, drq}, 8'h01);
        pulse_req(); hrd(3'd6, v);
        chk("R14 block drq held", {7'b0, drq}, 8'h01);
        hwr(3'd2, 8'h00);
        chk("R14 DMA off ends transfer", {7'b0, drq}, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule